// File: doc/BRIEF.md
# Dual-Scaling Fixed-Point Encoder

This block turns a two's complement fixed-point sample with a known binary point into a compact word. The word carries a significand that can be read at one of two fixed scalings. The top bit of the word picks the scaling. When it is clear, the significand counts in steps of 2^-P0, which gives a fine, narrow range. When it is set, the significand counts in steps of 2^-P1 (P1 < P0), which gives a coarse, wide range. The encoder uses the fine range whenever the sample fits there and falls back to the coarse range otherwise. This keeps small signals precise and still lets large signals through with fewer fractional bits.

Both candidate quantisations are computed in parallel from the input. A mode pin chooses between two quantisers. The first is a plain floor, which drops the low bits. The second is a guarded round-to-nearest, which adds one step when the first discarded bit is set, unless that would push the significand past its most positive code. The result is registered once and qualified by a valid flag.

Top module: `dfx_encoder`

## Requirements
- R1: Bit N-1 of `out_word` is the range flag, where 0 means the fine range and 1 means the coarse range. Bits N-2..0 hold an (N-1)-bit two's complement significand S. The encoded value is S·2^-P0 when the flag is 0 and S·2^-P1 when it is 1.
- R2: Let the input integer be X, read with IN_FRAC fractional bits. The fine range is chosen exactly when T0 = floor(X·2^(P0-IN_FRAC)) lies in [-2^(N-2), 2^(N-2)-1]. Otherwise the coarse range is chosen.
- R3: With `round_mode` = 0, the significand is the floor (rounding toward negative infinity) of the input rescaled to the chosen range.
- R4: With `round_mode` = 1, the floor result gets one added when the input bit just below the chosen range's LSB is 1, so ties round upward.
- R5: The increment of R4 is skipped when the floor significand already equals 2^(N-2)-1. A fine-range result therefore never wraps, for any input.
- R6: If the coarse-range floor T1 = floor(X·2^(P1-IN_FRAC)) lies outside the significand range, the significand saturates to 2^(N-2)-1 for positive inputs or -2^(N-2) for negative inputs.
- R7: `out_valid` equals `in_valid` from the previous clock edge. `out_word` is the encoding of the inputs sampled at that edge.
- R8: On an edge where `in_valid` is 0, `out_word` keeps its previous value, whatever `in_word` and `round_mode` hold.
- R9: Active-low `rst_n` clears `out_valid` and `out_word` to zero.
- R10: A coarse-range output has a significand sign equal to the sign of the input it came from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_word | input | IN_W | Two's complement input with IN_FRAC fractional bits |
| round_mode | input | 1 | 0 = floor, 1 = guarded round-to-nearest |
| out_valid | output | 1 | Output qualifier, one cycle after in_valid |
| out_word | output | N | Range flag in the MSB, significand below it |

## Verification
The bench sweeps every input code of a small configuration in both modes. This covers the edges between the fine and coarse ranges where R2 decides which range is used. If the fit test were done on the rounded value instead, or off by one code, the range flag would come out wrong at those edges. The sweep also hits inputs whose floor is the most positive fine code with the round bit set. A design without the R5 guard would wrap those to the most negative code. The sweep reaches far beyond the coarse range too, so missing saturation shows up as wrapped significands. Idle cycles with changed inputs check that an unqualified sample leaves the held word alone.

// File: rtl/dfx_enc_pkg.sv
package dfx_enc_pkg;

   typedef enum logic {
      QM_FLOOR = 1'b0,
      QM_NEAR  = 1'b1
   } qmode_e;

   typedef enum logic {
      RNG_FINE   = 1'b0,
      RNG_COARSE = 1'b1
   } range_e;

endpackage

// File: rtl/dfx_range_quant.sv
module dfx_range_quant #(
   parameter int IN_W     = 32,
   parameter int SHIFT    = 3,
   parameter int SIG_W    = 15,
   parameter bit SATURATE = 1'b0
) (
   input  logic [IN_W-1:0]  in_word,
   input  logic             round_en,
   output logic [SIG_W-1:0] sig,
   output logic             fits
);

   localparam int T_W = IN_W - SHIFT;
   localparam logic [SIG_W-1:0] SIG_MAX = {1'b0, {(SIG_W-1){1'b1}}};
   localparam logic [SIG_W-1:0] SIG_MIN = {1'b1, {(SIG_W-1){1'b0}}};

   initial begin
      shift_range_chk: assert (SHIFT >= 0 && SHIFT < IN_W)
         else $error("dfx_range_quant: SHIFT out of range");
      width_chk: assert (T_W >= SIG_W && SIG_W >= 2)
         else $error("dfx_range_quant: truncated width below significand width");
   end

   logic [T_W-1:0]   floor_val;
   logic             round_bit;
   logic             at_max;
   logic             bump;
   logic [SIG_W-1:0] rounded;

   assign floor_val = in_word[IN_W-1:SHIFT];

   // bit just below the kept LSB, if any bit is dropped
   generate
      if (SHIFT > 0) begin : g_rbit
         assign round_bit = in_word[SHIFT-1];
      end else begin : g_no_rbit
         assign round_bit = 1'b0;
      end
      if (SHIFT > 1) begin : g_sticky
         logic unused_low;
         assign unused_low = ^in_word[SHIFT-2:0];
      end
   endgenerate

   // the value fits when every bit above the significand repeats its sign
   generate
      if (T_W > SIG_W) begin : g_fit_test
         logic [T_W-SIG_W:0] upper;
         assign upper = floor_val[T_W-1:SIG_W-1];
         assign fits  = (&upper) | ~(|upper);
      end else begin : g_fit_always
         assign fits = 1'b1;
      end
   endgenerate

   assign at_max  = (floor_val[SIG_W-1:0] == SIG_MAX);
   assign bump    = round_en & round_bit & ~at_max;
   assign rounded = floor_val[SIG_W-1:0] + {{(SIG_W-1){1'b0}}, bump};

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (fits) begin
               sig = rounded;
            end else if (floor_val[T_W-1]) begin
               sig = SIG_MIN;
            end else begin
               sig = SIG_MAX;
            end
         end
      end else begin : g_plain
         assign sig = rounded;
      end
   endgenerate

endmodule

// File: rtl/dfx_range_select.sv
module dfx_range_select
   import dfx_enc_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-2:0] fine_sig,
   input  logic         fine_fits,
   input  logic [N-2:0] coarse_sig,
   output logic [N-1:0] word
);

   initial begin
      word_width_chk: assert (N >= 3)
         else $error("dfx_range_select: word too narrow");
   end

   range_e rng;

   always_comb begin
      rng = fine_fits ? RNG_FINE : RNG_COARSE;
      unique case (rng)
         RNG_FINE:   word = {1'b0, fine_sig};
         RNG_COARSE: word = {1'b1, coarse_sig};
         default:    word = '0;
      endcase
   end

endmodule

// File: rtl/dfx_encoder.sv
module dfx_encoder
   import dfx_enc_pkg::*;
#(
   parameter int IN_W    = 32,
   parameter int IN_FRAC = 22,
   parameter int N       = 16,
   parameter int P0      = 19,
   parameter int P1      = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [IN_W-1:0] in_word,
   input  logic            round_mode,
   output logic            out_valid,
   output logic [N-1:0]    out_word
);

   localparam int SIG_W  = N - 1;
   localparam int SH_FIN = IN_FRAC - P0;
   localparam int SH_CRS = IN_FRAC - P1;

   initial begin
      scale_order_chk: assert (IN_FRAC >= P0 && P0 > P1)
         else $error("dfx_encoder: need IN_FRAC >= P0 > P1");
      scale_gap_chk: assert (P0 - P1 < N - 2)
         else $error("dfx_encoder: scale gap too wide for significand");
      coarse_width_chk: assert (IN_W - SH_CRS >= SIG_W)
         else $error("dfx_encoder: input too narrow for coarse range");
   end

   qmode_e           qmode;
   logic             near_en;
   logic [SIG_W-1:0] fine_sig;
   logic             fine_fits;
   logic [SIG_W-1:0] coarse_sig;
   logic             unused_coarse_fits;
   logic [N-1:0]     enc_word;

   assign qmode   = qmode_e'(round_mode);
   assign near_en = (qmode == QM_NEAR);

   dfx_range_quant #(
      .IN_W     (IN_W),
      .SHIFT    (SH_FIN),
      .SIG_W    (SIG_W),
      .SATURATE (1'b0)
   ) i_fine (
      .in_word  (in_word),
      .round_en (near_en),
      .sig      (fine_sig),
      .fits     (fine_fits)
   );

   dfx_range_quant #(
      .IN_W     (IN_W),
      .SHIFT    (SH_CRS),
      .SIG_W    (SIG_W),
      .SATURATE (1'b1)
   ) i_coarse (
      .in_word  (in_word),
      .round_en (near_en),
      .sig      (coarse_sig),
      .fits     (unused_coarse_fits)
   );

   dfx_range_select #(
      .N (N)
   ) i_select (
      .fine_sig   (fine_sig),
      .fine_fits  (fine_fits),
      .coarse_sig (coarse_sig),
      .word       (enc_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= enc_word;
         end
      end
   end

   // R7
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R7
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R8
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word));

   // R10
   coarse_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!out_word[N-1] || (out_word[N-2] == $past(in_word[IN_W-1]))));

endmodule

// File: tb/test_dfx_encoder.sv
module test_dfx_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int IN_W    = 10;
   localparam int IN_FRAC = 6;
   localparam int N       = 6;
   localparam int P0      = 5;
   localparam int P1      = 2;
   localparam int D0      = IN_FRAC - P0;
   localparam int D1      = IN_FRAC - P1;
   localparam int SMAX    = (1 << (N - 2)) - 1;
   localparam int SMIN    = -(1 << (N - 2));

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic [IN_W-1:0] in_word;
   logic            round_mode;
   logic            out_valid;
   logic [N-1:0]    out_word;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dfx_encoder #(
      .IN_W    (IN_W),
      .IN_FRAC (IN_FRAC),
      .N       (N),
      .P0      (P0),
      .P1      (P1)
   ) i_dfx_encoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_word    (in_word),
      .round_mode (round_mode),
      .out_valid  (out_valid),
      .out_word   (out_word)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected encoding and the requirement that governs it
   function automatic int expect_word(input int x, input bit rnd, output string tag);
      int t0, rem0, t1, rem1, q;
      t0   = x >>> D0;
      rem0 = x - (t0 << D0);
      if (t0 >= SMIN && t0 <= SMAX) begin
         q   = t0;
         tag = rnd ? "R2 R4" : "R2 R3";
         if (rnd && D0 > 0 && rem0 >= (1 << (D0 - 1))) begin
            if (t0 == SMAX) tag = "R2 R5";
            else q = t0 + 1;
         end
         return q & ((1 << (N - 1)) - 1);
      end
      t1   = x >>> D1;
      rem1 = x - (t1 << D1);
      tag  = rnd ? "R1 R4" : "R1 R3";
      if (t1 > SMAX) begin
         q = SMAX; tag = "R6";
      end else if (t1 < SMIN) begin
         q = SMIN; tag = "R6";
      end else begin
         q = t1;
         if (rnd && rem1 >= (1 << (D1 - 1)) && t1 != SMAX) q = t1 + 1;
      end
      return (1 << (N - 1)) | (q & ((1 << (N - 1)) - 1));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int last;
      string tag;
      rst_n      = 1'b0;
      in_valid   = 1'b0;
      in_word    = '0;
      round_mode = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 out_valid", int'(out_valid), 0);
      check("R9 out_word", int'(out_word), 0);
      rst_n = 1'b1;
      last  = 0;

      for (int m = 0; m < 2; m++) begin
         for (int x = -(1 << (IN_W - 1)); x < (1 << (IN_W - 1)); x++) begin
            int ew;
            in_valid   = 1'b1;
            in_word    = IN_W'(x);
            round_mode = m[0];
            ew         = expect_word(x, m[0], tag);
            @(negedge clk);
            check("R7 out_valid", int'(out_valid), 1);
            check(tag, int'(out_word), ew);
            last = ew;
            if ((x % 61) == 0) begin
               // R8: idle edge with different data must not disturb the word
               in_valid   = 1'b0;
               in_word    = ~IN_W'(x);
               round_mode = ~m[0];
               @(negedge clk);
               check("R7 idle out_valid", int'(out_valid), 0);
               check("R8 hold", int'(out_word), last);
            end
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule